// File: doc/BRIEF.md
# Shared-Memory Byte Ring Client

This block gives a host-side engine access to byte ring buffers that live in a target processor's external memory. It keeps a small descriptor per channel (buffer base address, index mask, and the host's own copies of the write and read positions). A command on the request stream names a channel and one of six operations: attach a channel to a ring, test for empty, test for full, take a byte without waiting, take a byte and wait for one, and put a byte and wait for room. The block answers each command with one record on the response stream.

Each ring has a three-byte header placed directly below its buffer. The header holds the mask, the producer position and the consumer position. Before it touches memory, the block asks for ownership of the target's bus on an ownership port. It then runs single-byte reads and writes on a memory port, and gives the bus back afterwards. Every position the block moves is written back into the header before it releases the bus, so the program on the target always sees the current state. A channel whose base is zero is not in use. The arbitration state machine and the electrical memory-cycle timing sit outside this block.

Top module: `rbx_ring_client`

## Requirements
- R1: Header bytes are addressed relative to the base, modulo 2^AW. The mask is at base-3, the producer (write) position at base-2 and the consumer (read) position at base-1. Buffer byte i is at base+i.
- R2: Attach (op 0) stores cmd_addr as the base. When the base is non-zero, the block takes one ownership and reads the mask, the producer position and the consumer position (three reads) into the descriptor, then releases the bus. The response has flag 0.
- R3: On a channel whose base is zero, ops 1 to 5 answer at once with flag 1, data 0 and err 0, and make no ownership or memory request.
- R4: Empty test (op 1) reads the producer position from memory. Flag is 1 exactly when that value equals the local consumer position.
- R5: Full test (op 2) reads the consumer position from memory. Flag is 1 exactly when ((local producer position + 1) AND mask) equals that value.
- R6: Non-blocking take (op 3) runs in a single ownership. It performs the empty test and, if the ring is empty, answers flag 1. Otherwise it reads base+consumer position, sets the consumer position to (consumer position + 1) AND mask, writes the new value to base-1, and answers with the byte and flag 0.
- R7: Put (op 5) writes cmd_data to base+producer position, sets the producer position to (producer position + 1) AND mask, and writes the new value to base-2. Both writes fall within one ownership. The response has flag 0.
- R8: Waiting take (op 4) and put (op 5) repeat their empty or full test, each attempt within its own take/release pair, until the condition clears. The transfer then runs in a fresh ownership.
- R9: If own_granted is low when an ownership request is acknowledged, the operation ends with err 1. No memory access follows, and the channel's descriptor keeps its earlier contents.
- R10: A command is accepted on a cycle with cmd_valid and cmd_ready both high. cmd_ready stays low from acceptance until the response is consumed. The response stays valid and stable until rsp_ready is high.
- R11: own_valid and mem_valid each stay high with stable own_take, mem_addr and mem_we until acknowledged. mem_valid is only raised while the block owns the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle and able to accept |
| cmd_op | input | 3 | 0 attach, 1 empty, 2 full, 3 take, 4 waiting take, 5 put |
| cmd_ch | input | CHW | Channel index |
| cmd_addr | input | AW | Base address for attach |
| cmd_data | input | DW | Byte to put |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_data | output | DW | Byte taken (0 otherwise) |
| rsp_flag | output | 1 | Empty/full result, or no data / channel unused |
| rsp_err | output | 1 | Bus ownership refused |
| own_valid | output | 1 | Ownership command pending |
| own_take | output | 1 | 1 acquire, 0 release |
| own_ack | input | 1 | Ownership command complete |
| own_granted | input | 1 | With own_ack on an acquire: bus obtained |
| mem_valid | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 write, 0 read |
| mem_addr | output | AW | Byte address |
| mem_wdata | output | DW | Write byte |
| mem_ready | input | 1 | Access complete; read data valid |
| mem_rdata | input | DW | Read byte |

## Verification
A stale local position shows at the ports on the next take or put to that channel. The returned byte comes from the wrong slot, or the wrong value is written into the header, in the same transaction. Broken ownership tracking shows as a memory strobe outside an acquire/release pair, or as a second acquire while the bus is still held. A descriptor that a refused request corrupts shows on the first successful take after the refusal, which reads from the wrong address. Waiting operations are checked by changing the header from the bench while the block polls, and then checking both the completion and the number of acquires.

// File: rtl/rbx_pkg.sv
package rbx_pkg;
  typedef enum logic [2:0] {
    OP_INIT  = 3'd0,
    OP_EMPTY = 3'd1,
    OP_FULL  = 3'd2,
    OP_GET   = 3'd3,
    OP_GETW  = 3'd4,
    OP_PUT   = 3'd5
  } rbx_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_TAKE, ST_MEM, ST_GIVE, ST_SAVE, ST_RESP
  } rbx_st_e;

  localparam int unsigned HDR_MASK_OFS = 3;
  localparam int unsigned HDR_IN_OFS   = 2;
  localparam int unsigned HDR_OUT_OFS  = 1;
endpackage

// File: rtl/rbx_desc_bank.sv
module rbx_desc_bank #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 8,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [CHW-1:0] rd_ch,
  output logic [AW-1:0]  rd_base,
  output logic [DW-1:0]  rd_mask,
  output logic [DW-1:0]  rd_in,
  output logic [DW-1:0]  rd_out,
  input  logic           wr_en,
  input  logic [CHW-1:0] wr_ch,
  input  logic [AW-1:0]  wr_base,
  input  logic [DW-1:0]  wr_mask,
  input  logic [DW-1:0]  wr_in,
  input  logic [DW-1:0]  wr_out
);
  logic [AW-1:0] base_r [NCH];
  logic [DW-1:0] mask_r [NCH];
  logic [DW-1:0] in_r   [NCH];
  logic [DW-1:0] out_r  [NCH];

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        base_r[g] <= '0;
        mask_r[g] <= '0;
        in_r[g]   <= '0;
        out_r[g]  <= '0;
      end else if (wr_en && wr_ch == CHW'(g)) begin
        base_r[g] <= wr_base;
        mask_r[g] <= wr_mask;
        in_r[g]   <= wr_in;
        out_r[g]  <= wr_out;
      end
    end
  end

  assign rd_base = base_r[rd_ch];
  assign rd_mask = mask_r[rd_ch];
  assign rd_in   = in_r[rd_ch];
  assign rd_out  = out_r[rd_ch];
endmodule

// File: rtl/rbx_addr_gen.sv
module rbx_addr_gen import rbx_pkg::*; #(
  parameter int unsigned AW = 16,
  parameter int unsigned DW = 8
) (
  input  rbx_op_e       op,
  input  logic          xfer,
  input  logic [1:0]    step,
  input  logic [AW-1:0] base,
  input  logic [DW-1:0] mask,
  input  logic [DW-1:0] idx_in,
  input  logic [DW-1:0] idx_out,
  input  logic [DW-1:0] data,
  output logic [AW-1:0] addr,
  output logic          we,
  output logic [DW-1:0] wdata,
  output logic          last
);
  logic [DW-1:0] nxt_in, nxt_out;
  assign nxt_in  = (idx_in  + DW'(1)) & mask;
  assign nxt_out = (idx_out + DW'(1)) & mask;

  always_comb begin
    addr  = base - AW'(HDR_IN_OFS);
    we    = 1'b0;
    wdata = '0;
    last  = 1'b1;
    if (op == OP_INIT) begin
      addr = base - AW'(HDR_MASK_OFS) + AW'(step);
      last = (step == 2'd2);
    end else if (!xfer) begin
      if (op == OP_FULL || op == OP_PUT) addr = base - AW'(HDR_OUT_OFS);
    end else if (op == OP_PUT) begin
      last = (step == 2'd1);
      we   = 1'b1;
      if (step == 2'd0) begin
        addr  = base + AW'(idx_in);
        wdata = data;
      end else begin
        wdata = nxt_in;
      end
    end else begin
      last = (step == 2'd1);
      if (step == 2'd0) begin
        addr = base + AW'(idx_out);
      end else begin
        addr  = base - AW'(HDR_OUT_OFS);
        we    = 1'b1;
        wdata = nxt_out;
      end
    end
  end
endmodule

// File: rtl/rbx_seq.sv
module rbx_seq import rbx_pkg::*; #(
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 8,
  parameter int unsigned CHW = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [CHW-1:0] cmd_ch,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_flag,
  output logic           rsp_err,
  output logic           own_valid,
  output logic           own_take,
  input  logic           own_ack,
  input  logic           own_granted,
  output logic           mem_valid,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [AW-1:0]  look_base,
  input  logic [DW-1:0]  look_mask,
  input  logic [DW-1:0]  look_in,
  input  logic [DW-1:0]  look_out,
  output logic           sv_en,
  output logic [CHW-1:0] sv_ch,
  output logic [AW-1:0]  sv_base,
  output logic [DW-1:0]  sv_mask,
  output logic [DW-1:0]  sv_in,
  output logic [DW-1:0]  sv_out
);
  rbx_st_e        st;
  rbx_op_e        op_q;
  logic [CHW-1:0] ch_q;
  logic [AW-1:0]  base_q;
  logic [DW-1:0]  mask_q, in_q, out_q, dat_q;
  logic [1:0]     step_q;
  logic           xfer_q, hit_q, err_q, owned_q;
  logic           ag_last, hit_now;
  logic [DW-1:0]  nin_q, nout_q;

  assign nin_q  = (in_q  + DW'(1)) & mask_q;
  assign nout_q = (out_q + DW'(1)) & mask_q;
  assign hit_now = (op_q == OP_FULL || op_q == OP_PUT) ? (nin_q == mem_rdata)
                                                       : (mem_rdata == out_q);

  rbx_addr_gen #(.AW(AW), .DW(DW)) u_ag (
    .op(op_q), .xfer(xfer_q), .step(step_q), .base(base_q), .mask(mask_q),
    .idx_in(in_q), .idx_out(out_q), .data(dat_q),
    .addr(mem_addr), .we(mem_we), .wdata(mem_wdata), .last(ag_last)
  );

  assign cmd_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign own_valid = (st == ST_TAKE) || (st == ST_GIVE);
  assign own_take  = (st == ST_TAKE);
  assign mem_valid = (st == ST_MEM);
  assign rsp_flag  = hit_q;
  assign rsp_err   = err_q;
  assign rsp_data  = (op_q == OP_GET || op_q == OP_GETW) ? dat_q : '0;
  assign sv_en     = (st == ST_SAVE);
  assign sv_ch     = ch_q;
  assign sv_base   = base_q;
  assign sv_mask   = mask_q;
  assign sv_in     = in_q;
  assign sv_out    = out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op_q <= OP_INIT; ch_q <= '0; base_q <= '0;
      mask_q <= '0; in_q <= '0; out_q <= '0; dat_q <= '0;
      step_q <= '0; xfer_q <= 1'b0; hit_q <= 1'b0; err_q <= 1'b0; owned_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (cmd_valid) begin
          op_q   <= rbx_op_e'(cmd_op);
          ch_q   <= cmd_ch;
          dat_q  <= (cmd_op == 3'(OP_PUT)) ? cmd_data : '0;
          mask_q <= look_mask;
          in_q   <= look_in;
          out_q  <= look_out;
          step_q <= '0;
          xfer_q <= 1'b0;
          hit_q  <= 1'b0;
          err_q  <= 1'b0;
          if (cmd_op == 3'(OP_INIT)) begin
            base_q <= cmd_addr;
            if (cmd_addr == '0) begin
              mask_q <= '0; in_q <= '0; out_q <= '0;
              st <= ST_SAVE;
            end else st <= ST_TAKE;
          end else begin
            base_q <= look_base;
            if (cmd_op > 3'(OP_PUT)) st <= ST_RESP;
            else if (look_base == '0) begin
              hit_q <= 1'b1;
              st    <= ST_RESP;
            end else st <= ST_TAKE;
          end
        end
        ST_TAKE: if (own_ack) begin
          step_q <= '0;
          if (own_granted) begin
            owned_q <= 1'b1;
            st      <= ST_MEM;
          end else begin
            err_q <= 1'b1;
            st    <= ST_RESP;
          end
        end
        ST_MEM: if (mem_ready) begin
          if (op_q == OP_INIT) begin
            case (step_q)
              2'd0:    mask_q <= mem_rdata;
              2'd1:    in_q   <= mem_rdata;
              default: out_q  <= mem_rdata;
            endcase
          end else if (!xfer_q) hit_q <= hit_now;
          else if (step_q == 2'd0 && op_q != OP_PUT) dat_q <= mem_rdata;
          if (!ag_last) step_q <= step_q + 2'd1;
          else begin
            if (xfer_q) begin
              if (op_q == OP_PUT) in_q <= nin_q;
              else                out_q <= nout_q;
            end
            if (!xfer_q && op_q == OP_GET && !hit_now) begin
              xfer_q <= 1'b1;
              step_q <= '0;
            end else st <= ST_GIVE;
          end
        end
        ST_GIVE: if (own_ack) begin
          owned_q <= 1'b0;
          if ((op_q == OP_GETW || op_q == OP_PUT) && !xfer_q) begin
            if (!hit_q) xfer_q <= 1'b1;
            step_q <= '0;
            st     <= ST_TAKE;
          end else if (op_q == OP_INIT || xfer_q) st <= ST_SAVE;
          else st <= ST_RESP;
        end
        ST_SAVE: st <= ST_RESP;
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  AST_MEM_OWNED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid |-> owned_q) else $error("memory access outside ownership"); // R11
  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_valid && !mem_ready |=> mem_valid && $stable(mem_addr) && $stable(mem_we)) else $error("memory request dropped"); // R11
  AST_OWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    own_valid && !own_ack |=> own_valid && $stable(own_take)) else $error("ownership request dropped"); // R11
  AST_NO_DOUBLE_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    own_valid && own_take |-> !owned_q) else $error("acquire while owning"); // R8
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable({rsp_data, rsp_flag, rsp_err})) else $error("response changed"); // R10
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rsp_valid && !mem_valid && !own_valid) else $error("busy while ready"); // R10
  AST_ERR_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_err |-> !owned_q) else $error("error with bus held"); // R9
endmodule

// File: rtl/rbx_ring_client.sv
module rbx_ring_client #(
  parameter int unsigned NCH = 4,
  parameter int unsigned AW  = 16,
  parameter int unsigned DW  = 8,
  localparam int unsigned CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_valid,
  output logic           cmd_ready,
  input  logic [2:0]     cmd_op,
  input  logic [CHW-1:0] cmd_ch,
  input  logic [AW-1:0]  cmd_addr,
  input  logic [DW-1:0]  cmd_data,
  output logic           rsp_valid,
  input  logic           rsp_ready,
  output logic [DW-1:0]  rsp_data,
  output logic           rsp_flag,
  output logic           rsp_err,
  output logic           own_valid,
  output logic           own_take,
  input  logic           own_ack,
  input  logic           own_granted,
  output logic           mem_valid,
  output logic           mem_we,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_wdata,
  input  logic           mem_ready,
  input  logic [DW-1:0]  mem_rdata
);
  logic [AW-1:0]  lk_base, sv_base;
  logic [DW-1:0]  lk_mask, lk_in, lk_out, sv_mask, sv_in, sv_out;
  logic           sv_en;
  logic [CHW-1:0] sv_ch;

  rbx_desc_bank #(.NCH(NCH), .AW(AW), .DW(DW)) u_bank (
    .clk(clk), .rst_n(rst_n), .rd_ch(cmd_ch),
    .rd_base(lk_base), .rd_mask(lk_mask), .rd_in(lk_in), .rd_out(lk_out),
    .wr_en(sv_en), .wr_ch(sv_ch), .wr_base(sv_base), .wr_mask(sv_mask),
    .wr_in(sv_in), .wr_out(sv_out)
  );

  rbx_seq #(.AW(AW), .DW(DW), .CHW(CHW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op), .cmd_ch(cmd_ch),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .rsp_flag(rsp_flag), .rsp_err(rsp_err),
    .own_valid(own_valid), .own_take(own_take), .own_ack(own_ack), .own_granted(own_granted),
    .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .look_base(lk_base), .look_mask(lk_mask), .look_in(lk_in), .look_out(lk_out),
    .sv_en(sv_en), .sv_ch(sv_ch), .sv_base(sv_base), .sv_mask(sv_mask),
    .sv_in(sv_in), .sv_out(sv_out)
  );
endmodule

// File: tb/tb_rbx_ring_client.sv
`timescale 1ns/1ps
module tb_rbx_ring_client;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0, cmd_ready;
  logic [2:0]  cmd_op = '0;
  logic [1:0]  cmd_ch = '0;
  logic [15:0] cmd_addr = '0;
  logic [7:0]  cmd_data = '0;
  logic        rsp_valid, rsp_ready = 1'b0, rsp_flag, rsp_err;
  logic [7:0]  rsp_data;
  logic        own_valid, own_take, own_ack = 1'b0, own_granted = 1'b0;
  logic        mem_valid, mem_we, mem_ready = 1'b0;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata, mem_rdata = '0;

  always #2.5 clk = ~clk;

  rbx_ring_client dut (.*);

  logic [7:0] mem [256];
  logic       deny = 1'b0;
  logic       pk_en = 1'b0;
  logic [7:0] pk_a = '0, pk_v = '0;
  int         ntake = 0, nmem = 0;
  int         nchk = 0, nfail = 0;
  logic [7:0] r_data;
  logic       r_flag, r_err;

  always @(posedge clk) begin
    own_ack     <= own_valid && !own_ack;
    own_granted <= !deny;
    mem_ready   <= mem_valid && !mem_ready;
    if (own_valid && !own_ack && own_take) ntake <= ntake + 1;
    if (mem_valid && !mem_ready) begin
      nmem <= nmem + 1;
      if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[7:0]];
    end
    if (pk_en) mem[pk_a] <= pk_v;
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic poke(input logic [7:0] a, input logic [7:0] v);
    @(negedge clk); pk_en = 1'b1; pk_a = a; pk_v = v;
    @(negedge clk); pk_en = 1'b0;
  endtask

  task automatic do_cmd(input logic [2:0] op, input logic [1:0] ch,
                        input logic [15:0] arg, input int hold);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_ch = ch; cmd_addr = arg; cmd_data = arg[7:0];
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!rsp_valid) @(negedge clk);
    r_data = rsp_data; r_flag = rsp_flag; r_err = rsp_err;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk("R10 response held", {rsp_valid, rsp_flag, rsp_data}, {1'b1, r_flag, r_data});
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // {op[2:0], ch[1:0], arg[15:0], flag, data[7:0], err}
  localparam int NV = 16;
  localparam logic [30:0] VEC [NV] = '{
    {3'd0, 2'd0, 16'h0010, 1'b0, 8'h00, 1'b0},  // R2 attach ch0
    {3'd0, 2'd1, 16'h0040, 1'b0, 8'h00, 1'b0},  // R2 attach ch1
    {3'd1, 2'd0, 16'h0000, 1'b0, 8'h00, 1'b0},  // R4 not empty
    {3'd2, 2'd0, 16'h0000, 1'b0, 8'h00, 1'b0},  // R5 not full
    {3'd2, 2'd1, 16'h0000, 1'b1, 8'h00, 1'b0},  // R5 full
    {3'd3, 2'd0, 16'h0000, 1'b0, 8'hA1, 1'b0},  // R6 take
    {3'd3, 2'd0, 16'h0000, 1'b0, 8'hB2, 1'b0},  // R6 take
    {3'd3, 2'd0, 16'h0000, 1'b1, 8'h00, 1'b0},  // R6 no data
    {3'd1, 2'd0, 16'h0000, 1'b1, 8'h00, 1'b0},  // R4 empty
    {3'd5, 2'd0, 16'h005C, 1'b0, 8'h00, 1'b0},  // R7 put
    {3'd3, 2'd0, 16'h0000, 1'b0, 8'h5C, 1'b0},  // R6 take put byte
    {3'd1, 2'd2, 16'h0000, 1'b1, 8'h00, 1'b0},  // R3 unused empty
    {3'd2, 2'd2, 16'h0000, 1'b1, 8'h00, 1'b0},  // R3 unused full
    {3'd3, 2'd2, 16'h0000, 1'b1, 8'h00, 1'b0},  // R3 unused take
    {3'd5, 2'd2, 16'h0011, 1'b1, 8'h00, 1'b0},  // R3 unused put
    {3'd0, 2'd3, 16'h0000, 1'b0, 8'h00, 1'b0}   // R2 attach zero
  };
  localparam string VREQ [NV] = '{"R2","R2","R4","R5","R5","R6","R6","R6",
                                  "R4","R7","R6","R3","R3","R3","R3","R2"};

  initial begin
    int t0, m0;
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    mem[8'h0D] = 8'h07; mem[8'h0E] = 8'h02; mem[8'h0F] = 8'h00;
    mem[8'h10] = 8'hA1; mem[8'h11] = 8'hB2;
    mem[8'h3D] = 8'h03; mem[8'h3E] = 8'h00; mem[8'h3F] = 8'h01;
    repeat (3) @(negedge clk);
    chk("R10 reset ready", {cmd_ready, rsp_valid, own_valid}, 3'b100);
    chk("R11 reset mem idle", mem_valid, 1'b0);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      do_cmd(VEC[i][30:28], VEC[i][27:26], VEC[i][25:10], 0);
      chk(VREQ[i], {r_flag, r_data, r_err}, VEC[i][9:0]);
    end

    t0 = ntake; m0 = nmem;
    do_cmd(3'd1, 2'd2, 16'h0, 0);
    chk("R3 no bus activity", {ntake - t0, nmem - m0}, 0);
    chk("R1 R6 consumer position published", mem[8'h0F], 8'h03);
    chk("R1 R7 producer position published", mem[8'h0E], 8'h03);
    chk("R7 byte stored", mem[8'h12], 8'h5C);

    poke(8'h7D, 8'h01); poke(8'h7E, 8'h01); poke(8'h7F, 8'h01);
    t0 = ntake; m0 = nmem;
    do_cmd(3'd0, 2'd3, 16'h0080, 0);
    chk("R2 one ownership", ntake - t0, 1);
    chk("R2 three header reads", nmem - m0, 3);

    do_cmd(3'd5, 2'd3, 16'h0033, 0);
    chk("R7 put flag", {r_flag, r_err}, 2'b00);
    chk("R7 wrap byte", mem[8'h81], 8'h33);
    chk("R7 wrap producer", mem[8'h7E], 8'h00);
    do_cmd(3'd3, 2'd3, 16'h0, 0);
    chk("R6 wrap take", {r_flag, r_data}, {1'b0, 8'h33});
    chk("R6 wrap consumer", mem[8'h7F], 8'h00);

    t0 = ntake;
    fork
      do_cmd(3'd4, 2'd3, 16'h0, 0);
      begin
        repeat (30) @(negedge clk);
        chk("R10 busy while waiting", cmd_ready, 1'b0);
        poke(8'h80, 8'h4D); poke(8'h7E, 8'h01);
      end
    join
    chk("R8 waiting take data", {r_flag, r_data, r_err}, {1'b0, 8'h4D, 1'b0});
    chk("R8 waiting take consumer", mem[8'h7F], 8'h01);
    chk("R8 repeated acquires", (ntake - t0) > 2, 1'b1);

    fork
      do_cmd(3'd5, 2'd1, 16'h0088, 0);
      begin repeat (30) @(negedge clk); poke(8'h3F, 8'h02); end
    join
    chk("R8 waiting put byte", mem[8'h40], 8'h88);
    chk("R8 waiting put producer", mem[8'h3E], 8'h01);

    @(negedge clk); deny = 1'b1;
    m0 = nmem;
    do_cmd(3'd3, 2'd0, 16'h0, 0);
    chk("R9 take refused", r_err, 1'b1);
    do_cmd(3'd0, 2'd0, 16'h0040, 0);
    chk("R9 attach refused", r_err, 1'b1);
    do_cmd(3'd5, 2'd0, 16'h00AA, 0);
    chk("R9 put refused", r_err, 1'b1);
    chk("R9 no memory access", nmem - m0, 0);
    @(negedge clk); deny = 1'b0;
    poke(8'h13, 8'hE7); poke(8'h0E, 8'h04);
    do_cmd(3'd3, 2'd0, 16'h0, 0);
    chk("R9 descriptor kept", {r_flag, r_data, r_err}, {1'b0, 8'hE7, 1'b0});
    chk("R9 consumer advanced from kept value", mem[8'h0F], 8'h04);

    do_cmd(3'd1, 2'd0, 16'h0, 4);
    chk("R10 held response value", r_flag, 1'b1);

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule